// File: doc/BRIEF.md
# SPI Flash Phased Transaction Engine

This block is the host side of a single-lane SPI link to a serial flash device. Software programs a small register file with one transaction: a command value, an address, the number of dummy clocks, the number of data bits to send and to receive, which of three chip selects to drive, and how long chip select stays low before the first clock and after the last one. Outgoing data is placed in a small word buffer first. Software then writes the start bit. The engine works through the enabled phases in a fixed order, drives the serial clock, the serial output and the chosen chip select, and places received bits back into the same buffer.

Software learns that the transaction has finished when the start bit reads back as zero. Each phase has its own enable bit and its own length field, and every length field holds the bit count minus one. The serial interface runs in SPI mode 0. The serial clock period is a fixed number of system clocks, set by a parameter.

Register map (word addresses on the 4-bit register port): 0 control (bit 0 start/busy); 1 command (bits 7:0 value, 10:8 length-1, 12 enable); 2 address (32 bits, left-justified); 3 address/dummy (bits 4:0 address length-1, 8 address enable, 19:16 dummy length-1, 24 dummy enable); 4 data lengths (bits 7:0 write length-1, 8 write enable, 23:16 read length-1, 24 read enable); 5 chip select (bits 1:0 select, 11:8 setup count, 19:16 hold count); 8 and up, buffer word n at address 8+n.

Top module: `spi_phase_engine`

## Requirements
- R1: Enabled phases run in the order setup, command, address, dummy, write data, read data, hold. A phase whose enable is clear (or whose setup or hold count is zero) takes no time. During dummy and read phases the serial output is 0. With every phase off, the transaction ends with no clock edge and no chip select asserted.
- R2: The command, address, dummy, write and read phases each last exactly their length field plus one serial clocks.
- R3: The command phase sends bits [len:0] of the command value, MSB first. Higher bits are not sent.
- R4: The address phase sends bits 31 down to 31-len of the address register, MSB first.
- R5: Writing 1 to control bit 0 while idle starts a transaction. Bit 0 reads 1 until the transaction ends, then reads 0. A start write during a transaction is ignored.
- R6: Chip select n (active low) is asserted only while a transaction is active and only when the select field equals n (n = 0, 1 or 2). A select value of 3 asserts none of them, and at most one is ever low.
- R7: With setup count S nonzero, the first serial clock rise comes (S+1)*DIV + DIV/2 system clocks after chip select falls. With S zero it comes DIV/2 system clocks after.
- R8: With hold count H, chip select rises H*DIV system clocks after the last serial clock fall. With H zero it rises together with that fall.
- R9: Write data is taken from the buffer as little-endian bytes: byte 0 of word 0 first, then byte 1, and so on, each byte MSB first.
- R10: Read bit j is stored at buffer byte j/8 (little-endian within words, starting at word 0), at bit 7-(j mod 8) of that byte. It is sampled on the serial clock rising edge. Buffer bits not covered by the read keep their contents.
- R11: The serial clock idles low. Each serial clock period is DIV system clocks, low for the first half and high for the second. The serial output changes only while the clock is low.
- R12: After reset, control reads 0, all chip selects are high, and the serial clock and serial output are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_waddr | input | 4 | Register write word address |
| reg_wdata | input | 32 | Register write data |
| reg_raddr | input | 4 | Register read word address |
| reg_rdata | output | 32 | Register read data (combinational) |
| spi_sclk | output | 1 | Serial clock, idles low |
| spi_mosi | output | 1 | Serial data to the flash device |
| spi_miso | input | 1 | Serial data from the flash device |
| spi_cs_n | output | 3 | Active-low chip selects |

## Verification
The hardest situation to reach from the ports is a start write arriving while a transaction is already running. The bench issues a second start partway through a long transaction. It then shows that the chip select fell only once and that the clock count equals exactly one transaction. The other hard part is telling whether a received bit landed at the right position across the read and write phases. The bench drives a position-dependent pattern on the serial input, changing it only on clock falls. It lets a read partly overwrite a buffer word that still holds write data, then lets a second read cross a word boundary, and compares whole buffer words against positions computed from the byte rule.

// File: rtl/spi_pe_pkg.sv
// Shared types for the SPI phased transaction engine.
// Assumes buffer depth is a power of two between 2 and 8 words.
package spi_pe_pkg;

    typedef enum logic [3:0] {
        PH_IDLE  = 4'd0,
        PH_SETUP = 4'd1,
        PH_CMD   = 4'd2,
        PH_ADDR  = 4'd3,
        PH_DUMMY = 4'd4,
        PH_WDATA = 4'd5,
        PH_RDATA = 4'd6,
        PH_HOLD  = 4'd7,
        PH_FIN   = 4'd8
    } phase_t;

    typedef struct packed {
        logic [7:0]  cmd_val;
        logic [2:0]  cmd_m1;
        logic        cmd_en;
        logic [31:0] addr;
        logic [4:0]  addr_m1;
        logic        addr_en;
        logic [3:0]  dum_m1;
        logic        dum_en;
        logic [7:0]  wr_m1;
        logic        wr_en;
        logic [7:0]  rd_m1;
        logic        rd_en;
        logic [1:0]  cs_sel;
        logic [3:0]  setup;
        logic [3:0]  hold;
    } cfg_t;

    localparam logic [3:0] RA_CTRL  = 4'd0;
    localparam logic [3:0] RA_CMD   = 4'd1;
    localparam logic [3:0] RA_ADDR  = 4'd2;
    localparam logic [3:0] RA_ALEN  = 4'd3;
    localparam logic [3:0] RA_DLEN  = 4'd4;
    localparam logic [3:0] RA_CSCFG = 4'd5;

endpackage

// File: rtl/spi_pe_regs.sv
// Register file and word buffer of the SPI phased transaction engine.
// Holds the transaction setup and the data buffer, and produces a one-cycle
// start pulse. Assumes software leaves the setup alone while busy. A receive
// write from the sequencer wins over a software write to the same word.
module spi_pe_regs
    import spi_pe_pkg::*;
#(
    parameter int NWORDS = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [3:0]               wr_addr,
    input  logic [31:0]              wr_data,
    input  logic [3:0]               rd_addr,
    output logic [31:0]              rd_data,
    input  logic                     busy,
    output logic                     start,
    output cfg_t                     cfg,
    output logic [NWORDS*32-1:0]     buf_flat,
    input  logic                     rx_we,
    input  logic [$clog2(NWORDS*32)-1:0] rx_pos,
    input  logic                     rx_bit
);
    localparam int POS_W = $clog2(NWORDS * 32);
    localparam int IDX_W = POS_W - 5;

    logic [31:0] words [NWORDS];

    // Start pulse: only a write of 1 to the control word while idle counts.
    assign start = wr_en && (wr_addr == RA_CTRL) && wr_data[0] && !busy;

    // Setup registers written by software.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                RA_CMD: begin
                    cfg.cmd_val <= wr_data[7:0];
                    cfg.cmd_m1  <= wr_data[10:8];
                    cfg.cmd_en  <= wr_data[12];
                end
                RA_ADDR: cfg.addr <= wr_data;
                RA_ALEN: begin
                    cfg.addr_m1 <= wr_data[4:0];
                    cfg.addr_en <= wr_data[8];
                    cfg.dum_m1  <= wr_data[19:16];
                    cfg.dum_en  <= wr_data[24];
                end
                RA_DLEN: begin
                    cfg.wr_m1 <= wr_data[7:0];
                    cfg.wr_en <= wr_data[8];
                    cfg.rd_m1 <= wr_data[23:16];
                    cfg.rd_en <= wr_data[24];
                end
                RA_CSCFG: begin
                    cfg.cs_sel <= wr_data[1:0];
                    cfg.setup  <= wr_data[11:8];
                    cfg.hold   <= wr_data[19:16];
                end
                default: ;
            endcase
        end
    end

    // One storage word per buffer entry, written by software or by receive.
    for (genvar i = 0; i < NWORDS; i++) begin : g_word
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                words[i] <= '0;
            end else if (rx_we && rx_pos[POS_W-1:5] == IDX_W'(i)) begin
                words[i][rx_pos[4:0]] <= rx_bit;
            end else if (wr_en && wr_addr[3] && wr_addr[2:0] == 3'(i)) begin
                words[i] <= wr_data;
            end
        end
        assign buf_flat[i*32 +: 32] = words[i];
    end

    // Read-back multiplexer.
    always_comb begin
        rd_data = '0;
        case (rd_addr)
            RA_CTRL:  rd_data[0] = busy;
            RA_CMD:   rd_data = {19'd0, cfg.cmd_en, 1'b0, cfg.cmd_m1, cfg.cmd_val};
            RA_ADDR:  rd_data = cfg.addr;
            RA_ALEN:  rd_data = {7'd0, cfg.dum_en, 4'd0, cfg.dum_m1, 7'd0,
                                 cfg.addr_en, 3'd0, cfg.addr_m1};
            RA_DLEN:  rd_data = {7'd0, cfg.rd_en, cfg.rd_m1, 7'd0, cfg.wr_en, cfg.wr_m1};
            RA_CSCFG: rd_data = {12'd0, cfg.hold, 4'd0, cfg.setup, 6'd0, cfg.cs_sel};
            default: begin
                if (rd_addr[3] && ({1'b0, rd_addr[2:0]} < 4'(NWORDS)))
                    rd_data = words[rd_addr[IDX_W-1:0]];
            end
        endcase
    end

endmodule

// File: rtl/spi_pe_seq.sv
// Phase sequencer of the SPI phased transaction engine.
// Steps through setup, command, address, dummy, write, read and hold slots,
// one serial clock period (SCK_DIV system clocks) per slot. Generates SPI
// mode 0 timing: clock low in the first half of a slot, high in the second.
// Assumes SCK_DIV is even and at least 2.
module spi_pe_seq
    import spi_pe_pkg::*;
#(
    parameter int NWORDS  = 4,
    parameter int SCK_DIV = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         start,
    input  cfg_t                         cfg,
    input  logic [NWORDS*32-1:0]         buf_flat,
    input  logic                         miso,
    output logic                         busy,
    output logic                         sclk,
    output logic                         mosi,
    output logic                         cs_act,
    output logic                         rx_we,
    output logic [$clog2(NWORDS*32)-1:0] rx_pos,
    output logic                         rx_bit
);
    localparam int POS_W = $clog2(NWORDS * 32);
    localparam int CNT_W = (SCK_DIV > 2) ? $clog2(SCK_DIV) : 1;
    localparam int HALF  = SCK_DIV / 2;

    phase_t           ph;
    logic [CNT_W-1:0] cnt;
    logic [7:0]       bidx;
    logic [7:0]       last_m1;
    logic [7:0]       pos8;
    logic             slot_end;
    logic             clocked;

    // First enabled phase that follows phase p; finish when none is left.
    function automatic phase_t next_after(input phase_t p, input cfg_t c);
        phase_t r;
        r = PH_FIN;
        if (p < PH_HOLD  && c.hold  != 4'd0) r = PH_HOLD;
        if (p < PH_RDATA && c.rd_en)         r = PH_RDATA;
        if (p < PH_WDATA && c.wr_en)         r = PH_WDATA;
        if (p < PH_DUMMY && c.dum_en)        r = PH_DUMMY;
        if (p < PH_ADDR  && c.addr_en)       r = PH_ADDR;
        if (p < PH_CMD   && c.cmd_en)        r = PH_CMD;
        if (p < PH_SETUP && c.setup != 4'd0) r = PH_SETUP;
        return r;
    endfunction

    // Last slot index of the current phase.
    always_comb begin
        case (ph)
            PH_SETUP: last_m1 = {4'd0, cfg.setup};
            PH_CMD:   last_m1 = {5'd0, cfg.cmd_m1};
            PH_ADDR:  last_m1 = {3'd0, cfg.addr_m1};
            PH_DUMMY: last_m1 = {4'd0, cfg.dum_m1};
            PH_WDATA: last_m1 = cfg.wr_m1;
            PH_RDATA: last_m1 = cfg.rd_m1;
            PH_HOLD:  last_m1 = {4'd0, cfg.hold} - 8'd1;
            default:  last_m1 = 8'd0;
        endcase
    end

    assign slot_end = (cnt == CNT_W'(SCK_DIV - 1));

    // Phase, slot counter and bit index update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph   <= PH_IDLE;
            cnt  <= '0;
            bidx <= '0;
        end else begin
            case (ph)
                PH_IDLE: begin
                    cnt  <= '0;
                    bidx <= '0;
                    if (start) ph <= next_after(PH_IDLE, cfg);
                end
                PH_FIN: ph <= PH_IDLE;
                default: begin
                    if (slot_end) begin
                        cnt <= '0;
                        if (bidx == last_m1) begin
                            ph   <= next_after(ph, cfg);
                            bidx <= '0;
                        end else begin
                            bidx <= bidx + 8'd1;
                        end
                    end else begin
                        cnt <= cnt + CNT_W'(1);
                    end
                end
            endcase
        end
    end

    // Serial clock only runs in the bit phases, high in the second half.
    assign clocked = (ph == PH_CMD) || (ph == PH_ADDR) || (ph == PH_DUMMY) ||
                     (ph == PH_WDATA) || (ph == PH_RDATA);
    assign sclk    = clocked && (cnt >= CNT_W'(HALF));
    assign busy    = (ph != PH_IDLE);
    assign cs_act  = (ph != PH_IDLE) && (ph != PH_FIN);

    // Buffer bit position: little-endian bytes, MSB first inside a byte.
    assign pos8 = {bidx[7:3], ~bidx[2:0]};

    // Serial output bit of the current slot.
    always_comb begin
        case (ph)
            PH_CMD:   mosi = cfg.cmd_val[cfg.cmd_m1 - bidx[2:0]];
            PH_ADDR:  mosi = cfg.addr[5'd31 - bidx[4:0]];
            PH_WDATA: mosi = buf_flat[pos8[POS_W-1:0]];
            default:  mosi = 1'b0;
        endcase
    end

    // Receive capture at the clock rise of each read slot.
    assign rx_we  = (ph == PH_RDATA) && (cnt == CNT_W'(HALF));
    assign rx_pos = pos8[POS_W-1:0];
    assign rx_bit = miso;

    AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !sclk);                                          // R11
    AST_MOSI_STABLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk && $past(sclk)) |-> $stable(mosi));                   // R11
    AST_BUSY_NEEDS_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));                              // R5
    AST_FIN_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (ph == PH_FIN) |=> !busy);                                  // R5

endmodule

// File: rtl/spi_pe_csdec.sv
// Chip-select decoder: asserts (low) exactly the selected line while the
// transaction is active. Select values at or above NCS assert nothing.
module spi_pe_csdec #(
    parameter int NCS = 3,
    parameter int SEL_W = 2
) (
    input  logic             act,
    input  logic [SEL_W-1:0] sel,
    output logic [NCS-1:0]   cs_n
);
    // One comparator per chip-select line.
    for (genvar i = 0; i < NCS; i++) begin : g_cs
        assign cs_n[i] = ~(act && (sel == SEL_W'(i)));
    end
endmodule

// File: rtl/spi_phase_engine.sv
// SPI flash phased transaction engine, top level.
// Joins the register file, the phase sequencer and the chip-select decoder.
// Single-lane SPI mode 0; SCK_DIV system clocks per serial clock.
module spi_phase_engine #(
    parameter int NWORDS  = 4,
    parameter int SCK_DIV = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_we,
    input  logic [3:0]  reg_waddr,
    input  logic [31:0] reg_wdata,
    input  logic [3:0]  reg_raddr,
    output logic [31:0] reg_rdata,
    output logic        spi_sclk,
    output logic        spi_mosi,
    input  logic        spi_miso,
    output logic [2:0]  spi_cs_n
);
    import spi_pe_pkg::*;

    localparam int POS_W = $clog2(NWORDS * 32);

    cfg_t                 cfg;
    logic                 busy;
    logic                 start;
    logic                 cs_act;
    logic [NWORDS*32-1:0] buf_flat;
    logic                 rx_we;
    logic [POS_W-1:0]     rx_pos;
    logic                 rx_bit;

    spi_pe_regs #(.NWORDS(NWORDS)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(reg_we), .wr_addr(reg_waddr), .wr_data(reg_wdata),
        .rd_addr(reg_raddr), .rd_data(reg_rdata),
        .busy(busy), .start(start), .cfg(cfg), .buf_flat(buf_flat),
        .rx_we(rx_we), .rx_pos(rx_pos), .rx_bit(rx_bit)
    );

    spi_pe_seq #(.NWORDS(NWORDS), .SCK_DIV(SCK_DIV)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .cfg(cfg),
        .buf_flat(buf_flat), .miso(spi_miso), .busy(busy),
        .sclk(spi_sclk), .mosi(spi_mosi), .cs_act(cs_act),
        .rx_we(rx_we), .rx_pos(rx_pos), .rx_bit(rx_bit)
    );

    spi_pe_csdec #(.NCS(3), .SEL_W(2)) u_csdec (
        .act(cs_act), .sel(cfg.cs_sel), .cs_n(spi_cs_n)
    );

    AST_ONE_CS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~spi_cs_n) <= 1);                                // R6
    AST_CS_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (spi_cs_n == 3'b111));                            // R6

endmodule

// File: tb/spi_phase_engine_bench.sv
// Directed bench for the SPI phased transaction engine.
module spi_phase_engine_bench;
    localparam int DIV = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_waddr = '0;
    logic [31:0] reg_wdata = '0;
    logic [3:0]  reg_raddr = '0;
    logic [31:0] reg_rdata;
    logic        spi_sclk, spi_mosi;
    logic        spi_miso = 1'b0;
    logic [2:0]  spi_cs_n;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    spi_phase_engine #(.NWORDS(4), .SCK_DIV(DIV)) u_spi_phase_engine (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_waddr(reg_waddr),
        .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
        .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
        .spi_cs_n(spi_cs_n)
    );

    // Flash-side monitor state.
    int   cyc = 0;
    int   nrise, cs_falls, bad_gap, bad_mosi;
    int   t_cs_fall, t_first_rise, t_last_rise, t_last_fall, t_cs_rise;
    logic [2:0] cs_seen;
    logic mon_bits [0:511];
    logic p_sclk = 1'b0, p_mosi = 1'b0, p_any = 1'b0;

    function automatic logic pat(input int k);
        return (((k * 5 + 1) % 3) == 0);
    endfunction

    task automatic clear_mon();
        nrise = 0; cs_falls = 0; bad_gap = 0; bad_mosi = 0;
        t_cs_fall = -1; t_first_rise = -1; t_last_rise = -1;
        t_last_fall = -1; t_cs_rise = -1; cs_seen = '0;
    endtask

    // Samples the serial pins between clock edges, acts as the flash device.
    always @(negedge clk) begin
        logic any;
        cyc <= cyc + 1;
        any = ~&spi_cs_n;
        if (rst_n) begin
            cs_seen <= cs_seen | ~spi_cs_n;
            if (any && !p_any) begin cs_falls <= cs_falls + 1; t_cs_fall <= cyc; end
            if (!any && p_any) t_cs_rise <= cyc;
            if (spi_sclk && !p_sclk) begin
                mon_bits[nrise] <= spi_mosi;
                nrise <= nrise + 1;
                if (t_first_rise < 0) t_first_rise <= cyc;
                else if (cyc - t_last_rise != DIV) bad_gap <= bad_gap + 1;
                t_last_rise <= cyc;
            end
            if (!spi_sclk && p_sclk) t_last_fall <= cyc;
            if (spi_sclk && p_sclk && spi_mosi != p_mosi) bad_mosi <= bad_mosi + 1;
            if ((!spi_sclk && p_sclk) || (any && !p_any)) spi_miso <= pat(nrise);
        end
        p_sclk <= spi_sclk; p_mosi <= spi_mosi; p_any <= any;
    end

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_waddr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_raddr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] v;
        for (int i = 0; i < 3000; i++) begin
            rd(4'd0, v);
            if (v[0] == 1'b0) break;
        end
        repeat (2) @(negedge clk);
    endtask

    task automatic cmp_bits(input string what, input int from, input int n,
                            input logic [255:0] exp_msb_first);
        int bad = 0;
        for (int i = 0; i < n; i++)
            if (mon_bits[from + i] !== exp_msb_first[n - 1 - i]) bad++;
        chk(what, bad, 0);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(4'd0, v);
        chk("R12 control after reset", v, 32'd0);
        chk("R12 chip selects after reset", {29'd0, spi_cs_n}, 32'd7);
        chk("R12 sclk/mosi after reset", {30'd0, spi_sclk, spi_mosi}, 32'd0);
    endtask

    task automatic t_full();
        logic [31:0] v, w0;
        int pos;
        clear_mon();
        wr(4'd8, 32'h0000_5AC3);
        wr(4'd1, 32'h0000_179F);                 // cmd 0x9F, 8 bits, enabled
        wr(4'd2, 32'hABCD_EFFF);                 // 24-bit address left-justified
        wr(4'd3, 32'h0103_0117);                 // addr 24, dummy 4
        wr(4'd4, 32'h010B_010F);                 // write 16, read 12
        wr(4'd5, 32'h0003_0201);                 // sel 1, setup 2, hold 3
        wr(4'd0, 32'd1);
        rd(4'd0, v);
        chk("R5 busy while running", v, 32'd1);
        repeat (30) @(negedge clk);
        wr(4'd0, 32'd1);                         // ignored restart
        wait_idle();
        rd(4'd0, v);
        chk("R5 start bit clears", v, 32'd0);
        chk("R5 restart ignored, one select", cs_falls, 1);
        chk("R2 total clock count", nrise, 64);
        cmp_bits("R3 command bits", 0, 8, 256'h9F);
        cmp_bits("R4 address bits", 8, 24, 256'hABCDEF);
        cmp_bits("R1 dummy bits zero", 32, 4, 256'h0);
        cmp_bits("R9 write bytes in order", 36, 16, 256'hC35A);
        cmp_bits("R1 read phase output zero", 52, 12, 256'h0);
        chk("R6 only select 1 used", {29'd0, cs_seen}, 32'd2);
        chk("R7 setup time", t_first_rise - t_cs_fall, 3 * DIV + DIV / 2);
        chk("R8 hold time", t_cs_rise - t_last_fall, 3 * DIV);
        chk("R11 clock period", bad_gap, 0);
        chk("R11 mosi steady while high", bad_mosi, 0);
        w0 = 32'h0000_5AC3;
        for (int j = 0; j < 12; j++) begin
            pos = (j / 8) * 8 + 7 - (j % 8);
            w0[pos] = pat(52 + j);
        end
        rd(4'd8, v);
        chk("R10 read merged into word 0", v, w0);
    endtask

    task automatic t_short_cmd();
        clear_mon();
        wr(4'd1, 32'h0000_14B5);                 // low 5 bits 10101
        wr(4'd3, 32'h0);
        wr(4'd4, 32'h0);
        wr(4'd5, 32'h0000_0000);                 // sel 0, no setup, no hold
        wr(4'd0, 32'd1);
        wait_idle();
        chk("R3 five-bit command count", nrise, 5);
        cmp_bits("R3 five-bit command value", 0, 5, 256'h15);
        chk("R7 no setup", t_first_rise - t_cs_fall, DIV / 2);
        chk("R8 no hold", t_cs_rise - t_last_fall, 0);
        chk("R6 select 0", {29'd0, cs_seen}, 32'd1);
    endtask

    task automatic t_no_select();
        logic [31:0] v;
        clear_mon();
        wr(4'd1, 32'h0000_17A5);
        wr(4'd5, 32'h0001_0103);                 // sel 3
        wr(4'd0, 32'd1);
        wait_idle();
        rd(4'd0, v);
        chk("R6 select 3 asserts none", {29'd0, cs_seen}, 32'd0);
        chk("R5 done with select 3", v, 32'd0);
        chk("R2 eight clocks with select 3", nrise, 8);
    endtask

    task automatic t_read_span();
        logic [31:0] v, w [2];
        int pos;
        clear_mon();
        wr(4'd8, 32'h0);
        wr(4'd9, 32'hFFFF_FFFF);
        wr(4'd1, 32'h0);
        wr(4'd4, 32'h0127_0000);                 // read 40 bits only
        wr(4'd5, 32'h0000_0002);
        wr(4'd0, 32'd1);
        wait_idle();
        w[0] = 32'h0; w[1] = 32'hFFFF_FFFF;
        for (int j = 0; j < 40; j++) begin
            pos = (j / 8) * 8 + 7 - (j % 8);
            w[pos / 32][pos % 32] = pat(j);
        end
        rd(4'd8, v);
        chk("R10 read word 0", v, w[0]);
        rd(4'd9, v);
        chk("R10 read word 1 partial", v, w[1]);
        cmp_bits("R1 output low in read-only", 0, 40, 256'h0);
        chk("R6 select 2", {29'd0, cs_seen}, 32'd4);
    endtask

    task automatic t_empty();
        logic [31:0] v;
        clear_mon();
        wr(4'd4, 32'h0);
        wr(4'd5, 32'h0);
        wr(4'd0, 32'd1);
        wait_idle();
        rd(4'd0, v);
        chk("R1 empty transaction ends", v, 32'd0);
        chk("R1 empty transaction no clocks", nrise, 0);
        chk("R1 empty transaction no select", cs_falls, 0);
    endtask

    initial begin
        clear_mon();
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_full();
        t_short_cmd();
        t_no_select();
        t_read_span();
        t_empty();
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule